// File: doc/BRIEF.md
# Smart-Card Receive Parity Error Signaler

This block decides, for every character taken in on a half-duplex smart-card link running the character-level protocol (T=0), whether the receiver must signal a parity error back to the sender. The signal is a low pulse, one elementary time unit (etu) long, on the shared open-drain I/O line during the guard period. The block only produces a pull-down enable. The pad drives the line low while the enable is high and leaves it to the pull-up otherwise. The block never drives the line high.

The character receiver pulses `char_done` at the centre of the parity bit, which is 9.5 etu after the start edge, and presents the parity check on `par_err` in the same cycle. A free-running `bit_tick` marks each bit centre. The error pulse starts at the first tick after `char_done`, which is the middle of the first guard bit at 10.5 etu, and ends at the following tick.

Two options change this behaviour. An inhibit bit removes the pulse altogether. A successive-error mode counts back-to-back parity failures. Once the count has reached a 3-bit programmed limit, the block stops asking for a resend and raises a sticky flag. Software then clears the flag and the count with a clear strobe.

Top module: `iso_t0_err_signaler`

## Requirements
- R1: After reset, `io_pull_dn`, `iter_flag` and `err_count` are all 0.
- R2: With `t0_en`=1, `succ_en`=0 and `nack_inhibit`=0, a `char_done` with `par_err`=1 causes the following behaviour. `io_pull_dn` goes to 1 after the first `bit_tick` edge strictly later than `char_done`. It then stays at 1 until the next `bit_tick` edge, after which it is 0.
- R3: With `nack_inhibit`=1, a parity error never raises `io_pull_dn`, and it leaves `err_count` and `iter_flag` unchanged.
- R4: A `char_done` with `par_err`=0 in T=0 mode produces no pulse and sets `err_count` to 0.
- R5: With `succ_en`=1, a parity error arriving while `err_count` < `max_iter` produces a pulse and increments `err_count` by one.
- R6: With `succ_en`=1, a parity error arriving while `err_count` = `max_iter` produces no pulse, keeps `err_count` unchanged and sets `iter_flag`.
- R7: With `succ_en`=1 and `max_iter`=0, the first parity error sets `iter_flag` and produces no pulse.
- R8: `iter_flag` stays at 1 through later characters, including characters with good parity. `flag_clr` clears `iter_flag` and `err_count` to 0 one cycle later.
- R9: With `t0_en`=0, characters produce no pulse and leave `err_count` and `iter_flag` unchanged.
- R10: The configuration inputs are sampled only in the cycle of `char_done`. A change made after that cycle does not alter the pulse that character produces, whether the pulse is still pending or already active.
- R11: `io_pull_dn` changes value only on a clock edge where `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_en | input | 1 | 1 = link runs the T=0 character protocol |
| succ_en | input | 1 | 1 = count successive parity errors against the limit |
| nack_inhibit | input | 1 | 1 = never signal parity errors |
| max_iter | input | ITER_W (3) | Successive-error limit |
| char_done | input | 1 | One-cycle strobe at the parity-bit centre |
| par_err | input | 1 | Parity check failed; valid with `char_done` |
| bit_tick | input | 1 | One-cycle strobe at each etu bit centre |
| flag_clr | input | 1 | One-cycle strobe that clears the flag and the count |
| io_pull_dn | output | 1 | Open-drain pull-down enable for the I/O line |
| iter_flag | output | 1 | Sticky flag: the successive-error limit was reached |
| err_count | output | ITER_W (3) | Current count of successive parity errors |

## Verification
A wrong count shows up at the ports within one cycle of the character strobe on `err_count`. It also shows up one tick later at the line, because the pulse for the limit-crossing character is either missing or extra. A lost pending request is seen at the first tick after the character, when `io_pull_dn` fails to rise. A stuck pulse timer is seen at the next tick, when the line is not released. A corrupted sticky flag is caught on the first character or clear strobe that follows it. The directed tests sample after each of these events.

// File: rtl/iso_t0_pkg.sv
package iso_t0_pkg;

  // Outcome of the per-character decision
  typedef struct packed {
    logic nack;       // request an error pulse on the line
    logic bump;       // increment the successive-error count
    logic hit_limit;  // limit reached: raise the sticky flag
    logic zero;       // good character: restart the count
  } verdict_t;

endpackage

// File: rtl/iso_t0_err_policy.sv
module iso_t0_err_policy
  import iso_t0_pkg::*;
#(
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t0_en,
  input  logic              succ_en,
  input  logic              nack_inhibit,
  input  logic [ITER_W-1:0] max_iter,
  input  logic              char_done,
  input  logic              par_err,
  input  logic              flag_clr,
  output logic              nack_req,
  output logic [ITER_W-1:0] err_count,
  output logic              iter_flag
);

  localparam logic [ITER_W-1:0] CNT_ONE = ITER_W'(1);

  verdict_t          vd;
  logic [ITER_W-1:0] cnt_q, cnt_d;
  logic              flag_q, flag_d;

  // Decision, using configuration as seen at the character strobe
  always_comb begin
    vd = '0;
    if (char_done && t0_en) begin
      if (!par_err) begin
        vd.zero = 1'b1;
      end else if (!nack_inhibit) begin
        if (!succ_en) begin
          vd.nack = 1'b1;
        end else if (cnt_q < max_iter) begin
          vd.nack = 1'b1;
          vd.bump = 1'b1;
        end else begin
          vd.hit_limit = 1'b1;
        end
      end
    end
  end

  // Next state of the count and the flag
  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (flag_clr) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else begin
      if (vd.zero)      cnt_d  = '0;
      if (vd.bump)      cnt_d  = cnt_q + CNT_ONE;
      if (vd.hit_limit) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign nack_req  = vd.nack;
  assign err_count = cnt_q;
  assign iter_flag = flag_q;

endmodule

// File: rtl/iso_t0_nack_drv.sv
module iso_t0_nack_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic nack_req,
  input  logic bit_tick,
  output logic pull_dn
);

  logic pend_q, pend_d;
  logic pull_q, pull_d;

  // A request waits for the next tick, then the line is held for one etu
  always_comb begin
    pend_d = pend_q;
    pull_d = pull_q;
    if (bit_tick) begin
      if (pull_q) begin
        pull_d = 1'b0;
      end else if (pend_q) begin
        pull_d = 1'b1;
        pend_d = 1'b0;
      end
    end
    if (nack_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pull_q <= pull_d;
    end
  end

  assign pull_dn = pull_q;

endmodule

// File: rtl/iso_t0_err_signaler.sv
module iso_t0_err_signaler #(
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t0_en,
  input  logic              succ_en,
  input  logic              nack_inhibit,
  input  logic [ITER_W-1:0] max_iter,
  input  logic              char_done,
  input  logic              par_err,
  input  logic              bit_tick,
  input  logic              flag_clr,
  output logic              io_pull_dn,
  output logic              iter_flag,
  output logic [ITER_W-1:0] err_count
);

  logic nack_req;

  iso_t0_err_policy #(.ITER_W(ITER_W)) policy_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .t0_en        (t0_en),
    .succ_en      (succ_en),
    .nack_inhibit (nack_inhibit),
    .max_iter     (max_iter),
    .char_done    (char_done),
    .par_err      (par_err),
    .flag_clr     (flag_clr),
    .nack_req     (nack_req),
    .err_count    (err_count),
    .iter_flag    (iter_flag)
  );

  iso_t0_nack_drv drv_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .nack_req (nack_req),
    .bit_tick (bit_tick),
    .pull_dn  (io_pull_dn)
  );

endmodule

// File: rtl/iso_t0_err_signaler_chk.sv
module iso_t0_err_signaler_chk #(
  parameter int ITER_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_done,
  input logic              par_err,
  input logic              t0_en,
  input logic              bit_tick,
  input logic              flag_clr,
  input logic              io_pull_dn,
  input logic              iter_flag,
  input logic [ITER_W-1:0] err_count
);

  // R11: the line enable moves only on a tick edge
  a_r11_pull_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(io_pull_dn) |-> $past(bit_tick));

  // R2: an active pulse holds until a tick
  a_r2_pull_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (io_pull_dn && !bit_tick) |=> io_pull_dn);

  // R2: an active pulse ends at the next tick
  a_r2_pull_one_etu: assert property (@(posedge clk) disable iff (!rst_n)
    (io_pull_dn && bit_tick) |=> !io_pull_dn);

  // R8: the flag is sticky until cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_flag && !flag_clr) |=> iter_flag);

  // R8: the clear empties flag and count
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!iter_flag && err_count == '0));

  // R4: a good character in T=0 mode restarts the count
  a_r4_good_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && t0_en && !par_err) |=> (err_count == '0));

  // R5: the count only moves on a character or a clear
  a_r5_count_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_count) |-> $past(char_done || flag_clr));

endmodule

bind iso_t0_err_signaler iso_t0_err_signaler_chk #(.ITER_W(ITER_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .char_done  (char_done),
  .par_err    (par_err),
  .t0_en      (t0_en),
  .bit_tick   (bit_tick),
  .flag_clr   (flag_clr),
  .io_pull_dn (io_pull_dn),
  .iter_flag  (iter_flag),
  .err_count  (err_count)
);

// File: tb/iso_t0_err_signaler_tb_top.sv
module iso_t0_err_signaler_tb_top;

  localparam int ITER_W = 3;

  logic              clk;
  logic              rst_n;
  logic              t0_en, succ_en, nack_inhibit;
  logic [ITER_W-1:0] max_iter;
  logic              char_done, par_err, bit_tick, flag_clr;
  logic              io_pull_dn, iter_flag;
  logic [ITER_W-1:0] err_count;

  int checks = 0;
  int errors = 0;

  iso_t0_err_signaler #(.ITER_W(ITER_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .t0_en(t0_en), .succ_en(succ_en),
    .nack_inhibit(nack_inhibit), .max_iter(max_iter), .char_done(char_done),
    .par_err(par_err), .bit_tick(bit_tick), .flag_clr(flag_clr),
    .io_pull_dn(io_pull_dn), .iter_flag(iter_flag), .err_count(err_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic send_char(input logic perr);
    @(negedge clk) begin char_done = 1'b1; par_err = perr; end
    @(negedge clk) begin char_done = 1'b0; par_err = 1'b0; end
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  // Character followed by the guard period; checks pulse presence and length
  task automatic char_and_guard(input logic perr, input int exp_pulse, input string req);
    send_char(perr);
    idle(2);
    chk({req, " no early pulse"}, io_pull_dn, 0);
    tick();
    chk({req, " pulse after first tick"}, io_pull_dn, exp_pulse);
    idle(3);
    chk({req, " pulse held"}, io_pull_dn, exp_pulse);
    tick();
    chk({req, " released after second tick"}, io_pull_dn, 0);
  endtask

  task automatic cfg(input logic t0, input logic succ, input logic inh, input int mx);
    @(negedge clk) begin
      t0_en = t0; succ_en = succ; nack_inhibit = inh; max_iter = ITER_W'(mx);
    end
  endtask

  task automatic t_reset();
    chk("R1 pull", io_pull_dn, 0);
    chk("R1 flag", iter_flag, 0);
    chk("R1 count", err_count, 0);
  endtask

  task automatic t_basic();
    cfg(1, 0, 0, 0);
    char_and_guard(1'b1, 1, "R2 basic error");
    char_and_guard(1'b0, 0, "R4 good parity plain mode");
  endtask

  task automatic t_inhibit();
    cfg(1, 1, 1, 2);
    char_and_guard(1'b1, 0, "R3 inhibit");
    chk("R3 count untouched", err_count, 0);
    chk("R3 flag untouched", iter_flag, 0);
  endtask

  task automatic t_good_resets();
    cfg(1, 1, 0, 5);
    char_and_guard(1'b1, 1, "R5 err1");
    char_and_guard(1'b1, 1, "R5 err2");
    chk("R5 count two", err_count, 2);
    char_and_guard(1'b0, 0, "R4 good char");
    chk("R4 count zeroed", err_count, 0);
  endtask

  task automatic t_limit();
    cfg(1, 1, 0, 3);
    for (int k = 1; k <= 3; k++) begin
      char_and_guard(1'b1, 1, "R5 counted error");
      chk("R5 count step", err_count, k);
      chk("R5 flag low below limit", iter_flag, 0);
    end
    char_and_guard(1'b1, 0, "R6 at limit");
    chk("R6 count held", err_count, 3);
    chk("R6 flag set", iter_flag, 1);
    char_and_guard(1'b1, 0, "R6 beyond limit");
    chk("R6 flag still set", iter_flag, 1);
    char_and_guard(1'b0, 0, "R8 good char keeps flag");
    chk("R8 flag sticky", iter_flag, 1);
    chk("R4 count zeroed after limit", err_count, 0);
    clear_flag();
    chk("R8 flag cleared", iter_flag, 0);
    chk("R8 count cleared", err_count, 0);
    char_and_guard(1'b1, 1, "R8 pulse after clear");
    chk("R8 count restarted", err_count, 1);
    clear_flag();
  endtask

  task automatic t_zero_max();
    cfg(1, 1, 0, 0);
    char_and_guard(1'b1, 0, "R7 zero limit");
    chk("R7 flag", iter_flag, 1);
    chk("R7 count", err_count, 0);
    clear_flag();
  endtask

  task automatic t_mode_off();
    cfg(1, 1, 0, 4);
    char_and_guard(1'b1, 1, "R9 prime");
    cfg(0, 1, 0, 4);
    char_and_guard(1'b1, 0, "R9 mode off error");
    chk("R9 count kept after error", err_count, 1);
    char_and_guard(1'b0, 0, "R9 mode off good");
    chk("R9 count kept after good", err_count, 1);
    chk("R9 flag untouched", iter_flag, 0);
    clear_flag();
  endtask

  task automatic t_cfg_timing();
    cfg(1, 0, 0, 0);
    // inhibit raised while the request is pending
    send_char(1'b1);
    cfg(1, 0, 1, 0);
    tick();
    chk("R10 pending pulse kept", io_pull_dn, 1);
    tick();
    chk("R10 pending pulse ends", io_pull_dn, 0);
    // inhibit raised while the pulse is active
    cfg(1, 0, 0, 0);
    send_char(1'b1);
    tick();
    cfg(1, 0, 1, 0);
    idle(2);
    chk("R10 active pulse kept", io_pull_dn, 1);
    tick();
    chk("R10 active pulse ends", io_pull_dn, 0);
    // the new setting applies to the next character
    char_and_guard(1'b1, 0, "R10 next char inhibited");
  endtask

  initial begin
    rst_n = 1'b0; t0_en = 1'b0; succ_en = 1'b0; nack_inhibit = 1'b0;
    max_iter = '0; char_done = 1'b0; par_err = 1'b0; bit_tick = 1'b0; flag_clr = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    t_reset();
    t_basic();
    t_inhibit();
    t_good_resets();
    t_limit();
    t_zero_max();
    t_mode_off();
    t_cfg_timing();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule